// File: doc/BRIEF.md
# Serial Control Port Register Slave

This block is the slave end of a four-wire serial control port that sits in front of a bank of 8-bit mode registers. A host drops an active-low frame select, clocks a read/write flag, a 7-bit register index and then data bits on the serial input, and releases frame select when it is done. Writes can be single-byte or continue as a burst of further data bytes to consecutive indices. A read returns the indexed register on the serial output during the second half of the frame. The output pad is driven only while read data is being shifted out.

All three serial inputs are asynchronous to the system clock. They are brought into the system clock domain through two-stage synchronisers, and the serial clock edges are detected there. Internal logic sees every register in parallel on one flat vector.

Top module: `scp_slave`

## Requirements
- R1: After reset every register reads zero on `regs_flat` and `sdo_oe` is low.
- R2: A frame is sampled on serial clock rising edges while `cs_n` is low. Bit 1 is the direction flag, where 0 means write and 1 means read. Bits 2 to 8 are the register index, most significant bit first. Bits 9 to 16 are a data byte, most significant bit first.
- R3: A single write changes the addressed register only after `cs_n` returns high. The register keeps its old value while `cs_n` stays low after the 16th clock.
- R4: In a write burst, each further 8 clocks after the first 16 bits carry a byte for the previous index plus one, wrapping from 127 to 0. Each byte except the last is committed when its 8th bit arrives. The last byte is committed when `cs_n` rises.
- R5: During a read, `sdo` carries the indexed register from bit 7 down to bit 0 on rising clocks 9 to 16. `sdo` changes only after serial clock falling edges.
- R6: `sdo_oe` rises after the falling edge that follows rising clock 8 of a read frame. It falls after the falling edge that follows rising clock 16, or when `cs_n` goes high. It is low at all other times, including all write frames.
- R7: A read frame leaves every register unchanged.
- R8: If `cs_n` rises before a frame has 16 bits, no register changes. If it rises in the middle of a burst byte, the partial byte is dropped and the complete bytes before it are kept.
- R9: While `cs_n` is high, activity on `sck` and `sdi` changes no register and does not enable `sdo`.
- R10: Register k appears on `regs_flat[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sck | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out level for the pad driver |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| regs_flat | output | 1024 | Parallel view of all registers |

## Verification
The bench uses a burst that starts at index 126. A design that does not wrap the index would write past the bank or drop the bytes meant for 0 and 1. It checks a register in the middle of a burst while frame select is still low. A design that holds every byte until the end, or that commits the final byte early, shows the wrong value there. Aborted frames, one short of a header and one partway into a second burst byte, catch designs that commit partial shifts. The bench samples the output enable before every serial rising edge of a read. This exposes an enable that turns on during the header or stays on after the eighth data bit.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // Frame phase: header shift, write data, read data out, read finished
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic frame_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  localparam int NSIG = 3;
  // bit 0: cs_n (resets high), bit 1: sck, bit 2: sdi
  localparam logic [NSIG-1:0] RST_VAL = 3'b001;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] stg_q [STAGES];
  logic            sck_q;

  assign raw = {sdi, sck, cs_n};

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else if (s == 0) stg_q[s] <= raw;
        else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= stg_q[STAGES-1][1];
  end

  assign frame_act = ~stg_q[STAGES-1][0];
  assign sdi_s     = stg_q[STAGES-1][2];
  assign sck_rise  = stg_q[STAGES-1][1] & ~sck_q;
  assign sck_fall  = ~stg_q[STAGES-1][1] & sck_q;
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [ADDR_W-1:0]            raddr,
  output logic [DATA_W-1:0]            rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0] flat
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit;
      assign hit = we && (waddr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[i] <= '0;
        else if (hit) mem_q[i] <= wdata;
      end
      assign flat[i*DATA_W +: DATA_W] = mem_q[i];
    end
  endgenerate

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int HDR_W = 1 + ADDR_W;
  localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(SH_W) + 1;
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DAT_CNT  = CNT_W'(DATA_W);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, rcnt_q, rcnt_d;
  logic [SH_W-1:0]   sh_q, sh_d, sh_new;
  logic [ADDR_W-1:0] addr_q, addr_d, paddr_q, paddr_d;
  logic [DATA_W-1:0] pdata_q, pdata_d, rsh_q, rsh_d;
  logic              pend_q, pend_d, oe_q, oe_d, sdo_q, sdo_d;

  assign sh_new  = {sh_q[SH_W-2:0], sdi_s};
  assign rd_addr = sh_new[ADDR_W-1:0];
  assign wr_addr = paddr_q;
  assign wr_data = pdata_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rcnt_d  = rcnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    pend_d  = pend_q;
    rsh_d   = rsh_q;
    oe_d    = oe_q;
    sdo_d   = sdo_q;
    wr_en   = 1'b0;
    if (!frame_act) begin
      wr_en   = pend_q;        // final complete byte commits on deselect
      phase_d = PH_HDR;
      cnt_d   = '0;
      rcnt_d  = '0;
      pend_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      if (sck_rise) begin
        unique case (phase_q)
          PH_HDR: begin
            sh_d  = sh_new;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == HDR_LAST) begin
              cnt_d  = '0;
              addr_d = sh_new[ADDR_W-1:0];
              if (sh_new[HDR_W-1]) begin
                phase_d = PH_RD;
                rsh_d   = rd_data;
              end else begin
                phase_d = PH_WR;
              end
            end
          end
          PH_WR: begin
            sh_d  = sh_new;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == DAT_LAST) begin
              cnt_d   = '0;
              wr_en   = pend_q;    // previous byte of a burst
              pend_d  = 1'b1;
              pdata_d = sh_new[DATA_W-1:0];
              paddr_d = addr_q;
              addr_d  = addr_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && (phase_q == PH_RD)) begin
        if (rcnt_q == DAT_CNT) begin
          oe_d    = 1'b0;
          phase_d = PH_DONE;
        end else begin
          oe_d   = 1'b1;
          sdo_d  = rsh_q[DATA_W-1];
          rsh_d  = {rsh_q[DATA_W-2:0], 1'b0};
          rcnt_d = rcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HDR;
      cnt_q   <= '0;
      rcnt_q  <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
      pend_q  <= 1'b0;
      rsh_q   <= '0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rcnt_q  <= rcnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
      pend_q  <= pend_d;
      rsh_q   <= rsh_d;
      oe_q    <= oe_d;
      sdo_q   <= sdo_d;
    end
  end
endmodule

// File: rtl/scp_slave.sv
module scp_slave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          sck,
  input  logic                          sdi,
  output logic                          sdo,
  output logic                          sdo_oe,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat
);
  logic              frame_act, sck_rise, sck_fall, sdi_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  scp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .frame_act(frame_act), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_s(sdi_s)
  );

  scp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  scp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data), .flat(regs_flat)
  );
endmodule

// File: rtl/scp_slave_chk.sv
module scp_slave_chk #(
  parameter int FLAT_W = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_act,
  input logic              sck_fall,
  input logic              wr_en,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [FLAT_W-1:0] regs_flat
);
  // R6: enable stays off across a deselected stretch
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_act && !$past(frame_act)) |-> !sdo_oe);

  // R6: enable moves only after a serial falling edge or a deselect
  p_oe_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_oe) |-> ($past(sck_fall) || !$past(frame_act)));

  // R5: output bit is held between serial falling edges
  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> $stable(sdo));

  // R3: register contents change only after a commit strobe
  p_reg_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(wr_en));

  // R7: no commit while read data is on the pad
  p_no_wr_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !wr_en);
endmodule

bind scp_slave scp_slave_chk #(.FLAT_W((1<<ADDR_W)*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .sck_fall(sck_fall),
  .wr_en(wr_en), .sdo(sdo), .sdo_oe(sdo_oe), .regs_flat(regs_flat)
);

// File: tb/test_scp_slave.sv
`timescale 1ns/1ps
module test_scp_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [1023:0] regs_flat;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [128];
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  scp_slave i_scp_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .regs_flat(regs_flat)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int a);
    return regs_flat[8*a +: 8];
  endfunction

  task automatic check_regs(input string tag);
    int bad = -1;
    for (int a = 0; a < 128; a++)
      if (reg_at(a) !== model[a] && bad < 0) bad = a;
    if (bad < 0) chk(1, tag, 0, 0);
    else chk(0, $sformatf("%s R10 reg %0d", tag, bad), reg_at(bad), model[bad]);
  endtask

  task automatic bit_out(input logic b, output logic en_at_rise);
    @(negedge clk); sdi = b;
    repeat (8) @(negedge clk);
    en_at_rise = sdo_oe;
    sck = 1'b1;
    repeat (8) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n, output int en_hits);
    logic e;
    en_hits = 0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_out(v[i], e);
      if (e) en_hits++;
    end
  endtask

  task automatic start_frame;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic end_frame;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic write_burst(input int a, input logic [7:0] d [], input string tag);
    int h;
    int tot = 0;
    start_frame();
    send({8'h00, 1'b0, 7'(a)}, 8, h); tot += h;
    foreach (d[k]) begin
      send({8'h00, d[k]}, 8, h); tot += h;
    end
    chk(tot == 0, {tag, " R6 enable during write"}, tot, 0);
    end_frame();
    foreach (d[k]) model[(a + k) % 128] = d[k];
    check_regs(tag);
  endtask

  task automatic do_read(input int a);
    int h;
    logic e;
    start_frame();
    exp_q.push_back(model[a]);
    send({8'h00, 1'b1, 7'(a)}, 8, h);
    chk(h == 0, "R6 enable during read header", h, 0);
    h = 0;
    for (int i = 0; i < 8; i++) begin
      bit_out(1'b0, e);
      if (e) h++;
    end
    chk(h == 8, "R6 enable during read data", h, 8);
    repeat (8) @(negedge clk);
    chk(sdo_oe == 1'b0, "R6 enable after 16th clock", sdo_oe, 0);
    end_frame();
    check_regs("R7 read leaves registers");
  endtask

  // Monitor: collects read bytes at serial rising edges and scores them
  initial begin
    int nb = 0;
    logic [7:0] acc = '0;
    logic [7:0] e;
    forever begin
      @(posedge sck);
      if (sdo_oe) begin
        acc = {acc[6:0], sdo};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) chk(0, "R5 unexpected read byte", acc, 0);
          else begin
            e = exp_q.pop_front();
            chk(acc === e, "R5 read data", acc, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int h;
    logic e;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(regs_flat == '0, "R1 registers zero after reset", 0, 0);
    chk(sdo_oe == 1'b0, "R1 enable low after reset", sdo_oe, 0);

    // R3: single write holds off until deselect
    start_frame();
    send({1'b0, 7'h05, 8'hA5}, 16, h);
    repeat (10) @(negedge clk);
    chk(reg_at(5) == 8'h00, "R3 no commit before deselect", reg_at(5), 0);
    end_frame();
    model[5] = 8'hA5;
    check_regs("R3 single write");
    chk(reg_at(5) == 8'hA5, "R2 bit order of single write", reg_at(5), 8'hA5);

    write_burst(7'h7F, '{8'h3C}, "R2 write top index");
    write_burst(7'h00, '{8'h81}, "R2 write index zero");

    // R4: burst with mid-frame commit check
    start_frame();
    send({1'b0, 7'h10, 8'h11}, 16, h);
    send(16'h0022, 8, h);
    send(16'h0033, 8, h);
    repeat (8) @(negedge clk);
    chk(reg_at(8'h10) == 8'h11, "R4 first burst byte committed", reg_at(8'h10), 8'h11);
    chk(reg_at(8'h11) == 8'h22, "R4 second burst byte committed", reg_at(8'h11), 8'h22);
    chk(reg_at(8'h12) == 8'h00, "R4 newest byte still pending", reg_at(8'h12), 0);
    send(16'h0044, 8, h);
    send(16'h0055, 8, h);
    end_frame();
    model[8'h10] = 8'h11; model[8'h11] = 8'h22; model[8'h12] = 8'h33;
    model[8'h13] = 8'h44; model[8'h14] = 8'h55;
    check_regs("R4 five-byte burst");

    // R4: index wraps from 127 to 0
    write_burst(7'h7E, '{8'hDE, 8'hAD, 8'hBE, 8'hEF}, "R4 burst wrap");

    // R5/R6/R7: reads of written locations
    do_read(7'h05);
    do_read(7'h11);
    do_read(7'h7F);
    do_read(7'h01);
    do_read(7'h14);

    // R8: frame aborted inside the header/data
    start_frame();
    send({6'h00, 1'b0, 7'h20, 2'b11}, 10, h);
    end_frame();
    check_regs("R8 short frame discarded");

    // R8: burst aborted mid-byte keeps the complete byte
    start_frame();
    send({1'b0, 7'h30, 8'h66}, 16, h);
    send(16'h000F, 4, h);
    end_frame();
    model[8'h30] = 8'h66;
    check_regs("R8 partial burst byte dropped");
    chk(reg_at(8'h31) == 8'h00, "R8 next index untouched", reg_at(8'h31), 0);

    // R9: serial activity while deselected
    h = 0;
    for (int i = 0; i < 24; i++) begin
      bit_out(i[0] ^ i[2], e);
      if (e) h++;
    end
    repeat (12) @(negedge clk);
    chk(h == 0, "R9 enable while deselected", h, 0);
    check_regs("R9 deselected activity ignored");

    do_read(7'h20);
    do_read(7'h30);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all read bytes produced", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule